// File: doc/BRIEF.md
# Serial-In Latched-Output Channel Controller

This block is the digital core of a sixteen-channel switch driver that is loaded over a three-wire serial link. Serial data is shifted into a chain on each rising edge of a serial clock. A rising edge on a latch strobe copies the chain into a storage register, which sets the channel outputs. On that same strobe edge, per-channel diagnostic status is loaded back into the chain. The status can then be shifted out on the serial output while the next word is shifted in. The serial output is the far end of the chain, so several controllers can be wired in series.

The serial clock, strobe and data arrive asynchronously. They are resynchronised to a system clock, and edges are found on that clock. Two active-low group enables gate the channel outputs in blocks of eight. An active-low clear blanks the storage register without disturbing shifting. An active-low device enable puts the whole block into standby. Odd channels carry one diagnostic input each. A fault flag reports any captured diagnostic on a channel that is currently driven.

Top module: `sldrv_core`

## Requirements
- R1: While `rst_n` is low, the chain, the storage register and the captured status are all zero, so `chan_on` is 0, `sdata_out` is 0 and `fault_flag` is 0.
- R2: `sclk_in`, `strobe_in` and `sdata_in` pass through a two-flop synchroniser. A rising edge of the synchronised serial clock moves chain bit i to bit i+1 and loads the synchronised data into bit 0. The chain changes on the third system clock edge that samples the raised serial clock.
- R3: `sdata_out` always shows chain bit 15. A bit shifted in appears on `sdata_out` after 16 shifts.
- R4: A rising edge of the synchronised strobe copies the chain into the storage register.
- R5: The same strobe edge loads a status vector into the chain and keeps a copy of it as the captured status. In that vector, bit 2k+1 equals `diag_in[k]` and every even bit is 0.
- R6: When a serial clock edge and a strobe edge are found in the same cycle, the latch acts first. Storage receives the chain as it was before the shift, and the chain becomes {status[14:0], data}.
- R7: While `clear_n` is low, storage is zero from the next clock on, including across strobe edges. Shifting and readback still work.
- R8: While `dev_en_n` is high, the chain, storage and captured status are zeroed on every clock, and serial clock and strobe edges have no effect. The edge detector keeps tracking the input levels, so an input that is already high when standby ends does not count as an edge.
- R9: `chan_on[i]` = storage[i] AND NOT `grp_en_n[i/8]`. `grp_en_n[0]` gates channels 0–7 and `grp_en_n[1]` gates channels 8–15. This gating is combinational.
- R10: `fault_flag` is the OR over all channels of (captured status AND `chan_on`). It is combinational on the registered state and the group enables.
- R11: A serial clock held high for many system clocks causes exactly one shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| sclk_in | input | 1 | Serial shift clock, asynchronous |
| strobe_in | input | 1 | Latch strobe, asynchronous |
| sdata_in | input | 1 | Serial data in |
| clear_n | input | 1 | Storage clear, active low |
| dev_en_n | input | 1 | Device enable, active low (high = standby) |
| grp_en_n | input | 2 | Group enables, active low; bit 0 for channels 0–7, bit 1 for 8–15 |
| diag_in | input | 8 | Diagnostic bits; bit k belongs to channel 2k+1 |
| sdata_out | output | 1 | Cascade output, chain MSB |
| chan_on | output | 16 | Channel drive controls |
| fault_flag | output | 1 | Fault on any driven channel |

## Verification
An irregular 16-bit word is shifted in and latched. A correct result rules out bit-order reversal and off-by-one shift errors, which a symmetric word would hide. Several diagnostic patterns are then read back through the serial output. These separate odd/even mapping mistakes and show whether the latch loads status or keeps the old chain. A strobe that coincides with a serial clock edge tells latch-first ordering apart from shift-first ordering. Clear, standby and long-held serial clock patterns confirm that storage blanking does not stop shifting, that edges seen in standby are lost, and that a level held high counts as a single edge.

// File: rtl/sldrv_pkg.sv
package sldrv_pkg;

    localparam int unsigned CH_COUNT = 16;
    localparam int unsigned GRP_SIZE = 8;

    typedef struct packed {
        logic sclk;
        logic strobe;
        logic sdata;
    } sldrv_raw_t;

endpackage

// File: rtl/sldrv_sync.sv
module sldrv_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int unsigned PW = W * STAGES;

    logic [PW-1:0] pipe_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[PW-W-1:0], din};
            end
        end
    endgenerate

    assign dout = pipe_q[PW-1 -: W];

endmodule

// File: rtl/sldrv_status_map.sv
module sldrv_status_map #(
    parameter int unsigned NCH = 16
) (
    input  logic [NCH/2-1:0] diag,
    output logic [NCH-1:0]   status
);

    localparam int unsigned NDIAG = NCH / 2;

    generate
        for (genvar k = 0; k < NDIAG; k++) begin : g_pair
            assign status[2*k]   = 1'b0;
            assign status[2*k+1] = diag[k];
        end
    endgenerate

endmodule

// File: rtl/sldrv_gate.sv
module sldrv_gate #(
    parameter int unsigned NCH = 16,
    parameter int unsigned GRP = 8
) (
    input  logic [NCH-1:0]     store,
    input  logic [NCH/GRP-1:0] grp_en_n,
    output logic [NCH-1:0]     on
);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            assign on[i] = store[i] & ~grp_en_n[i / GRP];
        end
    endgenerate

endmodule

// File: rtl/sldrv_core.sv
module sldrv_core
    import sldrv_pkg::*;
#(
    parameter int unsigned NCH         = CH_COUNT,
    parameter int unsigned GRP         = GRP_SIZE,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned NGRP       = NCH / GRP,
    localparam int unsigned NDIAG      = NCH / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_in,
    input  logic             strobe_in,
    input  logic             sdata_in,
    input  logic             clear_n,
    input  logic             dev_en_n,
    input  logic [NGRP-1:0]  grp_en_n,
    input  logic [NDIAG-1:0] diag_in,
    output logic             sdata_out,
    output logic [NCH-1:0]   chan_on,
    output logic             fault_flag
);

    localparam int unsigned RAW_W = $bits(sldrv_raw_t);

    typedef struct packed {
        logic [NCH-1:0] chain;
        logic [NCH-1:0] store;
        logic [NCH-1:0] stat;
        logic           sclk_prev;
        logic           stb_prev;
    } state_t;

    state_t     st_d, st_q;
    sldrv_raw_t raw_in, raw_s;
    logic [NCH-1:0] status_vec;
    logic shift_ev, latch_ev;

    assign raw_in = '{sclk: sclk_in, strobe: strobe_in, sdata: sdata_in};

    sldrv_sync #(
        .W      (RAW_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (raw_s)
    );

    sldrv_status_map #(
        .NCH (NCH)
    ) u_status (
        .diag   (diag_in),
        .status (status_vec)
    );

    assign shift_ev = raw_s.sclk   & ~st_q.sclk_prev;
    assign latch_ev = raw_s.strobe & ~st_q.stb_prev;

    always_comb begin
        logic [NCH-1:0] chain_v;
        st_d           = st_q;
        st_d.sclk_prev = raw_s.sclk;
        st_d.stb_prev  = raw_s.strobe;
        chain_v        = st_q.chain;
        if (dev_en_n) begin
            st_d.chain = '0;
            st_d.store = '0;
            st_d.stat  = '0;
        end else begin
            if (latch_ev) begin
                st_d.store = st_q.chain;
                st_d.stat  = status_vec;
                chain_v    = status_vec;
            end
            if (shift_ev) begin
                chain_v = {chain_v[NCH-2:0], raw_s.sdata};
            end
            st_d.chain = chain_v;
            if (!clear_n) begin
                st_d.store = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sldrv_gate #(
        .NCH (NCH),
        .GRP (GRP)
    ) u_gate (
        .store    (st_q.store),
        .grp_en_n (grp_en_n),
        .on       (chan_on)
    );

    assign sdata_out  = st_q.chain[NCH-1];
    assign fault_flag = |(st_q.stat & chan_on);

endmodule

// File: rtl/sldrv_core_chk.sv
module sldrv_core_chk #(
    parameter int unsigned NCH = 16,
    parameter int unsigned GRP = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clear_n,
    input logic               dev_en_n,
    input logic [NCH/GRP-1:0] grp_en_n,
    input logic               sdata_out,
    input logic [NCH-1:0]     chan_on,
    input logic               fault_flag
);

    function automatic logic [NCH-1:0] odd_mask();
        logic [NCH-1:0] m;
        m = '0;
        for (int i = 1; i < int'(NCH); i += 2) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [NCH-1:0] ODD_MASK = odd_mask();

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        dev_en_n |=> (chan_on == '0 && !sdata_out && !fault_flag)); // R8

    AST_CLEAR_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n |=> (chan_on == '0)); // R7

    AST_FAULT_ODD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> ((chan_on & ODD_MASK) != '0)); // R10

    generate
        for (genvar g = 0; g < int'(NCH / GRP); g++) begin : g_grp
            AST_GROUP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
                grp_en_n[g] |-> (chan_on[g*GRP +: GRP] == '0)); // R9
        end
    endgenerate

endmodule

bind sldrv_core sldrv_core_chk #(
    .NCH (NCH),
    .GRP (GRP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_n    (clear_n),
    .dev_en_n   (dev_en_n),
    .grp_en_n   (grp_en_n),
    .sdata_out  (sdata_out),
    .chan_on    (chan_on),
    .fault_flag (fault_flag)
);

// File: tb/sldrv_core_bench.sv
module sldrv_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk_in = 1'b0, strobe_in = 1'b0, sdata_in = 1'b0;
    logic        clear_n = 1'b1, dev_en_n = 1'b0;
    logic [1:0]  grp_en_n = 2'b00;
    logic [7:0]  diag_in = 8'h00;
    logic        sdata_out, fault_flag;
    logic [15:0] chan_on;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit model_on = 1'b0;

    always #5 clk = ~clk;

    sldrv_core u_sldrv_core (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .strobe_in(strobe_in),
        .sdata_in(sdata_in), .clear_n(clear_n), .dev_en_n(dev_en_n),
        .grp_en_n(grp_en_n), .diag_in(diag_in), .sdata_out(sdata_out),
        .chan_on(chan_on), .fault_flag(fault_flag)
    );

    function automatic logic [15:0] status_of(input logic [7:0] d);
        logic [15:0] s;
        s = '0;
        for (int k = 0; k < 8; k++) s[2*k+1] = d[k];
        return s;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: input history and three 16-bit words
    logic [3:0]  h_sck, h_stb, h_dat;
    logic [15:0] m_chain, m_store, m_stat;

    always @(posedge clk) begin
        if (!rst_n) begin
            h_sck = '0; h_stb = '0; h_dat = '0;
            m_chain = '0; m_store = '0; m_stat = '0;
        end else begin
            h_sck = {h_sck[2:0], sclk_in};
            h_stb = {h_stb[2:0], strobe_in};
            h_dat = {h_dat[2:0], sdata_in};
            if (dev_en_n) begin
                m_chain = '0; m_store = '0; m_stat = '0;
            end else begin
                if (h_stb[2] && !h_stb[3]) begin
                    m_store = m_chain;
                    m_stat  = status_of(diag_in);
                    m_chain = m_stat;
                end
                if (h_sck[2] && !h_sck[3]) m_chain = {m_chain[14:0], h_dat[2]};
                if (!clear_n) m_store = '0;
            end
        end
    end

    always @(negedge clk) begin
        logic [15:0] e_on;
        #2;
        if (model_on) begin
            e_on = m_store & {{8{~grp_en_n[1]}}, {8{~grp_en_n[0]}}};
            check("R2 R3 model sdata_out", {15'd0, sdata_out}, {15'd0, m_chain[15]});
            check("R4 R9 model chan_on", chan_on, e_on);
            check("R10 model fault_flag", {15'd0, fault_flag}, {15'd0, |(m_stat & e_on)});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected<150000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk);
        sdata_in = b; sclk_in = 1'b1;
        wait_n(2);
        sclk_in = 1'b0;
        wait_n(2);
    endtask

    task automatic shift_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic latch_pulse();
        @(negedge clk);
        strobe_in = 1'b1;
        wait_n(2);
        strobe_in = 1'b0;
        wait_n(2);
    endtask

    task automatic sample();
        @(negedge clk);
        #3;
    endtask

    initial begin
        logic [15:0] st;
        wait_n(3);
        #3;
        check("R1 reset chan_on", chan_on, 16'h0000);
        check("R1 reset sdata_out", {15'd0, sdata_out}, 16'h0000);
        check("R1 reset fault_flag", {15'd0, fault_flag}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R2 R4: irregular word shifted and latched
        shift_word(16'hC35A);
        sample();
        check("R3 cascade MSB", {15'd0, sdata_out}, 16'h0001);
        latch_pulse();
        sample();
        check("R4 latched word", chan_on, 16'hC35A);

        // R9 group gating
        grp_en_n = 2'b01; sample();
        check("R9 low group off", chan_on, 16'hC300);
        grp_en_n = 2'b10; sample();
        check("R9 high group off", chan_on, 16'h005A);
        grp_en_n = 2'b00;

        // R5 R10: status readback and fault
        shift_word(16'hFFFF);
        diag_in = 8'b1011_0010;
        latch_pulse();
        st = status_of(8'b1011_0010);
        sample();
        check("R10 fault on driven odd", {15'd0, fault_flag}, 16'h0001);
        grp_en_n = 2'b11; sample();
        check("R10 fault masked by groups", {15'd0, fault_flag}, 16'h0000);
        grp_en_n = 2'b00;
        diag_in = 8'h00;
        for (int j = 15; j >= 0; j--) begin
            sample();
            check("R5 status readback", {15'd0, sdata_out}, {15'd0, st[j]});
            shift_bit(1'b0);
        end

        // R6 simultaneous edges
        shift_word(16'h1234);
        diag_in = 8'hFF;
        @(negedge clk);
        sdata_in = 1'b1; sclk_in = 1'b1; strobe_in = 1'b1;
        wait_n(2);
        sclk_in = 1'b0; strobe_in = 1'b0;
        wait_n(2);
        diag_in = 8'h00;
        sample();
        check("R6 storage pre-shift", chan_on, 16'h1234);
        latch_pulse();
        sample();
        check("R6 chain status then data", chan_on, 16'h5555);

        // R7 clear blanks storage, shifting continues
        clear_n = 1'b0; sample();
        check("R7 clear blanks", chan_on, 16'h0000);
        latch_pulse();
        shift_word(16'h0F0F);
        sample();
        check("R7 latch during clear", chan_on, 16'h0000);
        clear_n = 1'b1; sample();
        check("R7 after clear release", chan_on, 16'h0000);
        latch_pulse();
        sample();
        check("R7 shift kept during clear", chan_on, 16'h0F0F);

        // R8 standby
        shift_word(16'hFFFF);
        dev_en_n = 1'b1; sample();
        check("R8 standby outputs", chan_on, 16'h0000);
        check("R8 standby sdata_out", {15'd0, sdata_out}, 16'h0000);
        shift_bit(1'b1);
        latch_pulse();
        @(negedge clk);
        sdata_in = 1'b1; sclk_in = 1'b1;
        wait_n(3);
        dev_en_n = 1'b0;
        wait_n(4);
        sclk_in = 1'b0;
        wait_n(3);
        latch_pulse();
        sample();
        check("R8 edges lost in standby", chan_on, 16'h0000);

        // R11 held serial clock gives one shift
        @(negedge clk);
        sdata_in = 1'b1; sclk_in = 1'b1;
        wait_n(12);
        sclk_in = 1'b0; sdata_in = 1'b0;
        wait_n(3);
        latch_pulse();
        sample();
        check("R11 one shift per edge", chan_on, 16'h0001);

        wait_n(4);
        model_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule